// File: doc/BRIEF.md
# Indirect Index-Data Register Window

This block opens a small I/O-space window of two dword ports onto a larger memory-mapped register aperture. A host that can only reach I/O space selects a register by writing its offset into the selector port. It then reads or writes that register through the data port, and the block turns each such access into one transaction on the internal register bus.

The selector is masked when it is written, so it always holds a dword-aligned offset that lies inside the aperture. Data-port reads wait for the register bus to answer, however many cycles that takes, and only one transaction is outstanding at a time. Byte and word accesses are carried through. The access size is forwarded unchanged, byte enables are taken from the low I/O address bits, and data sits in little-endian byte lanes.

Top module: `idx_data_window`

## Requirements
- R1: After reset the selector holds zero, and ioRvalid, ioBusy, regRd and regWr are all low.
- R2: A write to the selector port (window dword at INDEX_OFFSET, default offset 0) stores ioWdata with every bit outside [11:2] cleared. A read of the selector port returns that masked value with ioRvalid high in the cycle after the read strobe.
- R3: Selector-port reads and writes never assert regRd or regWr.
- R4: A read strobe at the data port (selector offset + 4) gives a one-cycle regRd pulse in the next cycle. With it come regAddr equal to the selector value and regSize equal to ioSize.
- R5: After a data-port read, ioBusy stays high until regRvalid is seen. In the following cycle ioBusy is low and ioRvalid pulses for one cycle. ioRdata then holds regRdata shifted right by 8 times the byte lane and cut to the access size, with upper bits zero.
- R6: A write strobe at the data port gives a one-cycle regWr pulse in the next cycle. regAddr equals the selector value, and regWdata holds ioWdata shifted left by 8 times the byte lane.
- R7: The ioSize/regSize encoding is the byte count: 1, 2 or 4. The byte lane and byte enables follow from it:
  - size 1: lane = ioAddr[1:0], regBe = 1 << lane.
  - size 2: lane = 2*ioAddr[1], regBe = 4'b0011 << lane.
  - size 4: lane 0, regBe = 4'b1111.
- R8: A read at any other window offset (dwords 2 to 7 by default) returns zero with ioRvalid in the next cycle and no register-bus strobe.
- R9: A write at any other window offset leaves the selector unchanged and makes no register-bus strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 5 | Byte offset inside the I/O window |
| ioRd | input | 1 | I/O read strobe |
| ioWr | input | 1 | I/O write strobe |
| ioSize | input | 3 | Access size in bytes (1, 2, 4) |
| ioWdata | input | 32 | I/O write data, right-justified |
| ioRdata | output | 32 | I/O read data, right-justified |
| ioRvalid | output | 1 | I/O read data valid, one cycle |
| ioBusy | output | 1 | Data-port read awaiting the register bus |
| regAddr | output | 12 | Register-bus byte address (dword aligned) |
| regRd | output | 1 | Register-bus read strobe |
| regWr | output | 1 | Register-bus write strobe |
| regSize | output | 3 | Register-bus access size in bytes |
| regBe | output | 4 | Register-bus byte enables |
| regWdata | output | 32 | Register-bus write data, lane-aligned |
| regRdata | input | 32 | Register-bus read data, lane-aligned |
| regRvalid | input | 1 | Register-bus read data valid |

## Verification
The assertions assume that the host never asserts ioRd and ioWr together and issues nothing while ioBusy is high. They also assume ioSize is always 1, 2 or 4, and that the register bus raises regRvalid only while a data-port read is outstanding. The directed stimulus keeps to these rules. Every access is a single strobe cycle followed by idle cycles, and the bench's register model answers each regRd exactly once, after a chosen latency of zero or more cycles.

// File: rtl/idx_win_pkg.sv
package idx_win_pkg;

  typedef struct packed {
    logic idxLoad;
    logic busRd;
    logic busWr;
    logic rspIdx;
    logic rspZero;
    logic rspBus;
  } winStrobe_t;

  // byte lane of an access from its low address bits and size
  function automatic logic [1:0] laneOf(input logic [1:0] a, input logic [2:0] sz);
    case (sz)
      3'd1:    laneOf = a;
      3'd2:    laneOf = {a[1], 1'b0};
      default: laneOf = 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] beOf(input logic [1:0] a, input logic [2:0] sz);
    case (sz)
      3'd1:    beOf = 4'b0001 << laneOf(a, sz);
      3'd2:    beOf = 4'b0011 << laneOf(a, sz);
      default: beOf = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] v, input logic [1:0] lane,
                                          input logic [2:0] sz);
    logic [31:0] sh;
    sh = v >> (8 * lane);
    case (sz)
      3'd1:    extract = {24'b0, sh[7:0]};
      3'd2:    extract = {16'b0, sh[15:0]};
      default: extract = sh;
    endcase
  endfunction

endpackage

// File: rtl/idx_win_ctl.sv
module idx_win_ctl
  import idx_win_pkg::*;
#(
  parameter int IO_AW  = 5,
  parameter int IDX_DW = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic             ioRd,
  input  logic             ioWr,
  input  logic             regRvalid,
  output winStrobe_t       strobe,
  output logic             busy
);

  localparam int DW_BITS = IO_AW - 2;
  localparam logic [DW_BITS-1:0] IDX_SEL = DW_BITS'(IDX_DW);
  localparam logic [DW_BITS-1:0] DAT_SEL = DW_BITS'(IDX_DW + 1);

  typedef enum logic {IDLE, WAIT} ctlState_t;
  ctlState_t stateQ, stateD;

  logic hitIdx, hitData;
  assign hitIdx  = ioAddr[IO_AW-1:2] == IDX_SEL;
  assign hitData = ioAddr[IO_AW-1:2] == DAT_SEL;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    if (stateQ == IDLE) begin
      if (ioWr) begin
        strobe.idxLoad = hitIdx;
        strobe.busWr   = hitData;
      end else if (ioRd) begin
        if (hitIdx) strobe.rspIdx = 1'b1;
        else if (hitData) begin
          strobe.busRd = 1'b1;
          stateD       = WAIT;
        end else strobe.rspZero = 1'b1;
      end
    end else if (regRvalid) begin
      strobe.rspBus = 1'b1;
      stateD        = IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= IDLE;
    else       stateQ <= stateD;
  end

  assign busy = stateQ == WAIT;

  // input rule: host is quiet while a read is outstanding
  a_in_quiet_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(ioRd || ioWr));
  // input rule: no read and write in one cycle
  a_in_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd && ioWr));
  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regRvalid) |=> !busy);

endmodule

// File: rtl/idx_win_dp.sv
module idx_win_dp
  import idx_win_pkg::*;
#(
  parameter int IO_AW  = 5,
  parameter int REG_AW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strobe,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic [2:0]        ioSize,
  input  logic [31:0]       ioWdata,
  output logic [31:0]       ioRdata,
  output logic              ioRvalid,
  output logic [REG_AW-1:0] regAddr,
  output logic              regRd,
  output logic              regWr,
  output logic [2:0]        regSize,
  output logic [3:0]        regBe,
  output logic [31:0]       regWdata,
  input  logic [31:0]       regRdata
);

  logic [REG_AW-1:0] indexQ;
  logic [1:0]        laneQ;
  logic [1:0]        ioLane;

  assign ioLane = laneOf(ioAddr[1:0], ioSize);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ   <= '0;
      regAddr  <= '0;
      regRd    <= 1'b0;
      regWr    <= 1'b0;
      regSize  <= 3'd4;
      regBe    <= '0;
      regWdata <= '0;
      laneQ    <= '0;
      ioRdata  <= '0;
      ioRvalid <= 1'b0;
    end else begin
      regRd    <= strobe.busRd;
      regWr    <= strobe.busWr;
      ioRvalid <= strobe.rspIdx | strobe.rspZero | strobe.rspBus;
      if (strobe.idxLoad) indexQ <= {ioWdata[REG_AW-1:2], 2'b00};
      if (strobe.busRd || strobe.busWr) begin
        regAddr <= indexQ;
        regSize <= ioSize;
        regBe   <= beOf(ioAddr[1:0], ioSize);
        laneQ   <= ioLane;
      end
      if (strobe.busWr) regWdata <= ioWdata << (8 * ioLane);
      if (strobe.rspIdx)
        ioRdata <= extract({{(32-REG_AW){1'b0}}, indexQ}, ioLane, ioSize);
      else if (strobe.rspZero)
        ioRdata <= '0;
      else if (strobe.rspBus)
        ioRdata <= extract(regRdata, laneQ, regSize);
    end
  end

  a_r4_single_rd: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> !regRd);
  a_r6_single_wr: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> !regWr);
  a_r7_be_count: assert property (@(posedge clk) disable iff (!rstN)
    (regRd || regWr) |-> ($countones(regBe) == 32'(regSize)));
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (regRd || regWr) |-> (regAddr[1:0] == 2'b00));

endmodule

// File: rtl/idx_data_window.sv
module idx_data_window
  import idx_win_pkg::*;
#(
  parameter int APERTURE_BYTES = 4096,
  parameter int WINDOW_BYTES   = 32,
  parameter int INDEX_OFFSET   = 0,
  localparam int IO_AW  = $clog2(WINDOW_BYTES),
  localparam int REG_AW = $clog2(APERTURE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [2:0]        ioSize,
  input  logic [31:0]       ioWdata,
  output logic [31:0]       ioRdata,
  output logic              ioRvalid,
  output logic              ioBusy,
  output logic [REG_AW-1:0] regAddr,
  output logic              regRd,
  output logic              regWr,
  output logic [2:0]        regSize,
  output logic [3:0]        regBe,
  output logic [31:0]       regWdata,
  input  logic [31:0]       regRdata,
  input  logic              regRvalid
);

  localparam int IDX_DW = INDEX_OFFSET / 4;

  winStrobe_t strobe;

  idx_win_ctl #(.IO_AW(IO_AW), .IDX_DW(IDX_DW)) ctl_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .regRvalid(regRvalid), .strobe(strobe), .busy(ioBusy)
  );

  idx_win_dp #(.IO_AW(IO_AW), .REG_AW(REG_AW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioAddr(ioAddr), .ioSize(ioSize),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .ioRvalid(ioRvalid),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regSize(regSize),
    .regBe(regBe), .regWdata(regWdata), .regRdata(regRdata)
  );

  logic idxHit;
  assign idxHit = ioAddr[IO_AW-1:2] == (IO_AW-2)'(IDX_DW);

  a_r3_idx_no_bus: assert property (@(posedge clk) disable iff (!rstN)
    ((ioRd || ioWr) && !ioBusy && idxHit) |=> !(regRd || regWr));
  a_r5_rvalid_follows: assert property (@(posedge clk) disable iff (!rstN)
    (ioBusy && regRvalid) |=> ioRvalid);
  a_r4_rd_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    regRd |-> ioBusy);
  // input rule: sizes are byte counts 1, 2 or 4
  a_in_size_legal: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd || ioWr) |-> (ioSize == 3'd1 || ioSize == 3'd2 || ioSize == 3'd4));

endmodule

// File: tb/idx_data_window_tb.sv
module idx_data_window_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  ioAddr = '0;
  logic        ioRd = 1'b0, ioWr = 1'b0;
  logic [2:0]  ioSize = 3'd4;
  logic [31:0] ioWdata = '0;
  logic [31:0] ioRdata;
  logic        ioRvalid, ioBusy;
  logic [11:0] regAddr;
  logic        regRd, regWr;
  logic [2:0]  regSize;
  logic [3:0]  regBe;
  logic [31:0] regWdata;
  logic [31:0] regRdata = '0;
  logic        regRvalid = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  idx_data_window dut_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioSize(ioSize), .ioWdata(ioWdata), .ioRdata(ioRdata), .ioRvalid(ioRvalid),
    .ioBusy(ioBusy), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .regSize(regSize), .regBe(regBe), .regWdata(regWdata),
    .regRdata(regRdata), .regRvalid(regRvalid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  // one strobe cycle; returns at the negedge after the capturing edge
  task automatic ioAccess(input bit wr, input logic [4:0] a, input logic [2:0] sz,
                          input logic [31:0] wd);
    @(negedge clk);
    ioAddr = a; ioSize = sz; ioWdata = wd;
    ioRd = !wr; ioWr = wr;
    @(negedge clk);
    ioRd = 1'b0; ioWr = 1'b0;
  endtask

  task automatic selectorRead(input logic [31:0] exp, input string req);
    ioAccess(1'b0, 5'd0, 3'd4, 32'h0);
    chk({req, " sel rvalid"}, {31'b0, ioRvalid}, 32'd1);
    chk({req, " sel data"}, ioRdata, exp);
    chk("R3 no bus on sel read", {30'b0, regRd, regWr}, 32'd0);
  endtask

  task automatic tReset();
    chk("R1 rvalid", {31'b0, ioRvalid}, 32'd0);
    chk("R1 busy", {31'b0, ioBusy}, 32'd0);
    chk("R1 bus strobes", {30'b0, regRd, regWr}, 32'd0);
    selectorRead(32'h0, "R1");
  endtask

  task automatic tIndexMask();
    ioAccess(1'b1, 5'd0, 3'd4, 32'hFFFF_FFFF);
    chk("R3 no bus on sel write", {30'b0, regRd, regWr}, 32'd0);
    selectorRead(32'h0000_0FFC, "R2");
    ioAccess(1'b1, 5'd0, 3'd4, 32'h1234_5677);
    selectorRead(32'h0000_0674, "R2");
  endtask

  // data-port read with the register bus answering after lat cycles
  task automatic tDataRead(input logic [4:0] a, input logic [2:0] sz, input int lat,
                           input logic [31:0] model, input logic [3:0] expBe,
                           input logic [31:0] expData, input logic [11:0] expAddr);
    ioAccess(1'b0, a, sz, 32'h0);
    chk("R4 regRd pulse", {31'b0, regRd}, 32'd1);
    chk("R4 regAddr", {20'b0, regAddr}, {20'b0, expAddr});
    chk("R4 regSize", {29'b0, regSize}, {29'b0, sz});
    chk("R7 read be", {28'b0, regBe}, {28'b0, expBe});
    chk("R5 busy", {31'b0, ioBusy}, 32'd1);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk("R5 busy hold", {31'b0, ioBusy}, 32'd1);
      chk("R5 no early rvalid", {31'b0, ioRvalid}, 32'd0);
    end
    regRvalid = 1'b1; regRdata = model;
    @(negedge clk);
    regRvalid = 1'b0; regRdata = 32'hDEAD_BEEF;
    chk("R5 rvalid", {31'b0, ioRvalid}, 32'd1);
    chk("R5 data", ioRdata, expData);
    chk("R5 busy clear", {31'b0, ioBusy}, 32'd0);
    @(negedge clk);
    chk("R5 rvalid one cycle", {31'b0, ioRvalid}, 32'd0);
  endtask

  task automatic tDataWrite(input logic [4:0] a, input logic [2:0] sz, input logic [31:0] wd,
                            input logic [3:0] expBe, input logic [31:0] expWd,
                            input logic [11:0] expAddr);
    ioAccess(1'b1, a, sz, wd);
    chk("R6 regWr pulse", {31'b0, regWr}, 32'd1);
    chk("R6 regAddr", {20'b0, regAddr}, {20'b0, expAddr});
    chk("R6 regWdata", regWdata, expWd);
    chk("R7 write be", {28'b0, regBe}, {28'b0, expBe});
    chk("R6 regSize", {29'b0, regSize}, {29'b0, sz});
    @(negedge clk);
    chk("R6 regWr one cycle", {31'b0, regWr}, 32'd0);
  endtask

  task automatic tOtherOffset();
    for (int d = 2; d < 8; d++) begin
      ioAccess(1'b0, 5'(d * 4), 3'd4, 32'h0);
      chk("R8 rvalid", {31'b0, ioRvalid}, 32'd1);
      chk("R8 zero data", ioRdata, 32'h0);
      chk("R8 no bus", {30'b0, regRd, regWr}, 32'd0);
    end
  endtask

  task automatic tIgnoredWrite();
    ioAccess(1'b1, 5'd0, 3'd4, 32'h0000_0abc);
    ioAccess(1'b1, 5'd12, 3'd4, 32'h0000_0ff0);
    chk("R9 no bus", {30'b0, regRd, regWr}, 32'd0);
    ioAccess(1'b1, 5'd28, 3'd1, 32'h0000_0055);
    chk("R9 no bus", {30'b0, regRd, regWr}, 32'd0);
    selectorRead(32'h0000_0abc, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tIndexMask();
    ioAccess(1'b1, 5'd0, 3'd4, 32'h0000_0120);
    tDataRead(5'd4, 3'd4, 0, 32'h4433_2211, 4'b1111, 32'h4433_2211, 12'h120);
    tDataRead(5'd6, 3'd1, 3, 32'h4433_2211, 4'b0100, 32'h0000_0033, 12'h120);
    tDataRead(5'd7, 3'd1, 1, 32'h4433_2211, 4'b1000, 32'h0000_0044, 12'h120);
    tDataRead(5'd6, 3'd2, 5, 32'h4433_2211, 4'b1100, 32'h0000_4433, 12'h120);
    tDataRead(5'd4, 3'd2, 2, 32'h8877_6655, 4'b0011, 32'h0000_6655, 12'h120);
    ioAccess(1'b1, 5'd0, 3'd4, 32'h0000_1ffe);
    tDataWrite(5'd4, 3'd4, 32'hCAFE_F00D, 4'b1111, 32'hCAFE_F00D, 12'hFFC);
    tDataWrite(5'd7, 3'd1, 32'h0000_00AB, 4'b1000, 32'hAB00_0000, 12'hFFC);
    tDataWrite(5'd5, 3'd1, 32'h0000_00CD, 4'b0010, 32'h0000_CD00, 12'hFFC);
    tDataWrite(5'd6, 3'd2, 32'h0000_BEEF, 4'b1100, 32'hBEEF_0000, 12'hFFC);
    tOtherOffset();
    tIgnoredWrite();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule